// File: doc/BRIEF.md
# Watchdog Frequency Recovery Controller

This block guards a clock generator while software moves it to a new operating frequency. Software first loads a timeout in whole seconds and then sets the enable bit. If software does not clear the enable bit before the timeout runs out, the controller drives an active-low system reset pulse. It then forces the frequency selection to a programmed fall-back code. It keeps watching at that code. If the timeout runs out a second time, it issues another reset and returns the selection to the code latched from the board straps.

The controller drives the effective 5-bit frequency code that the synthesizer uses. It also raises one-cycle strobes toward the register file: copy the fall-back code into the frequency register and set the source bit to "register", clear the source bit back to "straps", clear the enable bit, and zero the signed micro-step register. A parameterized prescaler derives the one-second tick and the half-second reset pulse from the reference clock, so a bench can shrink both.

Top module: `freq_guard_wdt`

## Requirements
- R1: While no recovery is in progress, `freq_code_o` equals `sw_code_i` when `sw_src_i` is 1 and `strap_code_i` when `sw_src_i` is 0, for every code value.
- R2: With the enable bit set at a falling clock edge, `wd_rst_no` goes low after rising edge number max(N,1)*TICK_CYC+1 from that point, where N is the interval. An interval of 0 expires on the first tick.
- R3: The interval is captured when counting starts. Changing `wd_interval_i` while counting does not move the expiry.
- R4: Each reset pulse holds `wd_rst_no` low for exactly PULSE_CYC clock cycles, half a tick by default.
- R5: On the first expiry, `upd_fb_o`, `clr_en_o` and `clr_mstep_o` pulse for one cycle together with the fall of `wd_rst_no`. `freq_code_o` equals the fall-back code taken at that moment, through the pulse and the watch period that follows.
- R6: While watching at the fall-back code, a further max(N,1)*TICK_CYC cycles without acknowledgment cause a second pulse. That pulse comes with `upd_strap_o`, `clr_en_o` and `clr_mstep_o`, and `freq_code_o` equals `strap_code_i` from then on.
- R7: Clearing the enable bit before expiry stops the count. No pulse and no strobe follow, and the frequency code is unchanged.
- R8: Setting the enable bit while watching at the fall-back code acknowledges it. `clr_en_o` pulses, no further reset follows, and the fall-back code stays in force through the register.
- R9: At most one of `upd_fb_o` and `upd_strap_o` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wd_en_i | input | 1 | Watchdog enable bit from the register file |
| wd_interval_i | input | IV_W | Timeout in one-second ticks |
| fb_code_i | input | CODE_W | Programmed fall-back frequency code |
| sw_code_i | input | CODE_W | Frequency code held in the register file |
| sw_src_i | input | 1 | Code source: 1 register, 0 straps |
| strap_code_i | input | CODE_W | Strap code latched at power-up |
| freq_code_o | output | CODE_W | Effective frequency code |
| wd_rst_no | output | 1 | Active-low system reset pulse |
| upd_fb_o | output | 1 | Strobe: load fall-back code, set source to register |
| upd_strap_o | output | 1 | Strobe: set source back to straps |
| clr_en_o | output | 1 | Strobe: clear the enable bit |
| clr_mstep_o | output | 1 | Strobe: zero the micro-step register |

## Verification
The code selector is swept over all 32 codes with both source settings, so a swapped mux leg or a dropped bit shows up. The interval is swept from 0 through 7 and also set to 63. Measuring the exact cycle of the reset fall separates an off-by-one tick count and a missing zero-interval rule from a correct count. Four more sequences each separate one recovery path from the others: an unacknowledged double expiry, an acknowledged fall-back, an early disable, and an interval rewritten mid-count. Each is checked through the frequency code, the strobes and a modelled micro-step register.

// File: rtl/freq_guard_pkg.sv
package freq_guard_pkg;
   typedef enum logic [2:0] {
      FG_IDLE   = 3'd0,
      FG_RUN    = 3'd1,
      FG_PULSE1 = 3'd2,
      FG_WATCH  = 3'd3,
      FG_PULSE2 = 3'd4
   } fg_state_e;

   function automatic logic fg_in_pulse(input fg_state_e s);
      return (s == FG_PULSE1) || (s == FG_PULSE2);
   endfunction
endpackage

// File: rtl/fg_prescaler.sv
module fg_prescaler #(
   parameter int TICK_CYC  = 16,
   parameter int PULSE_CYC = 8,
   localparam int CNT_W    = (TICK_CYC > 1) ? $clog2(TICK_CYC) : 1
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic clr_i,
   output logic tick_o,
   output logic pulse_end_o
);
   logic [CNT_W-1:0] pre_q;

   assign tick_o      = (pre_q == CNT_W'(TICK_CYC - 1));
   assign pulse_end_o = (pre_q == CNT_W'(PULSE_CYC - 1));

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                pre_q <= '0;
      else if (clr_i || tick_o)   pre_q <= '0;
      else                        pre_q <= pre_q + 1'b1;
   end
endmodule

// File: rtl/fg_sec_counter.sv
module fg_sec_counter #(
   parameter int IV_W = 6
) (
   input  logic            clk_i,
   input  logic            rst_ni,
   input  logic            clr_i,
   input  logic            tick_i,
   input  logic [IV_W-1:0] limit_i,
   output logic            expire_o
);
   logic [IV_W-1:0] sec_q;
   logic [IV_W:0]   sec_nxt;

   assign sec_nxt  = {1'b0, sec_q} + {{IV_W{1'b0}}, 1'b1};
   assign expire_o = tick_i && (sec_nxt >= {1'b0, limit_i});

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      sec_q <= '0;
      else if (clr_i)   sec_q <= '0;
      else if (tick_i)  sec_q <= sec_nxt[IV_W-1:0];
   end
endmodule

// File: rtl/fg_code_mux.sv
module fg_code_mux
   import freq_guard_pkg::*;
#(
   parameter int CODE_W = 5
) (
   input  fg_state_e         state_i,
   input  logic              sw_src_i,
   input  logic [CODE_W-1:0] sw_code_i,
   input  logic [CODE_W-1:0] strap_code_i,
   input  logic [CODE_W-1:0] fb_hold_i,
   output logic [CODE_W-1:0] code_o
);
   always_comb begin
      unique case (state_i)
         FG_PULSE1, FG_WATCH: code_o = fb_hold_i;
         FG_PULSE2:           code_o = strap_code_i;
         default:             code_o = sw_src_i ? sw_code_i : strap_code_i;
      endcase
   end
endmodule

// File: rtl/freq_guard_wdt.sv
module freq_guard_wdt
   import freq_guard_pkg::*;
#(
   parameter int TICK_CYC  = 14_318_180,
   parameter int PULSE_CYC = TICK_CYC / 2,
   parameter int IV_W      = 6,
   parameter int CODE_W    = 5
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              wd_en_i,
   input  logic [IV_W-1:0]   wd_interval_i,
   input  logic [CODE_W-1:0] fb_code_i,
   input  logic [CODE_W-1:0] sw_code_i,
   input  logic              sw_src_i,
   input  logic [CODE_W-1:0] strap_code_i,
   output logic [CODE_W-1:0] freq_code_o,
   output logic              wd_rst_no,
   output logic              upd_fb_o,
   output logic              upd_strap_o,
   output logic              clr_en_o,
   output logic              clr_mstep_o
);
   if (TICK_CYC < 4) begin : g_bad_tick
      $error("TICK_CYC must be at least 4");
   end
   if (PULSE_CYC < 1 || PULSE_CYC >= TICK_CYC) begin : g_bad_pulse
      $error("PULSE_CYC must lie in 1 .. TICK_CYC-1");
   end
   if (IV_W < 1 || CODE_W < 1) begin : g_bad_width
      $error("IV_W and CODE_W must be positive");
   end

   fg_state_e         state_q, state_d;
   logic [IV_W-1:0]   iv_q;
   logic [CODE_W-1:0] fb_q;
   logic              tick, pulse_end, expire, cnt_clr;
   logic              go_fb, go_strap, ack;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         FG_IDLE:   if (wd_en_i) state_d = FG_RUN;
         FG_RUN:    if (!wd_en_i) state_d = FG_IDLE;
                    else if (expire) state_d = FG_PULSE1;
         FG_PULSE1: if (pulse_end) state_d = FG_WATCH;
         FG_WATCH:  if (wd_en_i) state_d = FG_IDLE;
                    else if (expire) state_d = FG_PULSE2;
         FG_PULSE2: if (pulse_end) state_d = FG_IDLE;
         default:   state_d = FG_IDLE;
      endcase
   end

   assign cnt_clr  = (state_d != state_q) || (state_q == FG_IDLE);
   assign go_fb    = (state_q == FG_RUN)   && (state_d == FG_PULSE1);
   assign go_strap = (state_q == FG_WATCH) && (state_d == FG_PULSE2);
   assign ack      = (state_q == FG_WATCH) && (state_d == FG_IDLE);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         state_q     <= FG_IDLE;
         iv_q        <= '0;
         fb_q        <= '0;
         upd_fb_o    <= 1'b0;
         upd_strap_o <= 1'b0;
         clr_en_o    <= 1'b0;
         clr_mstep_o <= 1'b0;
      end else begin
         state_q     <= state_d;
         if (state_q == FG_IDLE && wd_en_i) iv_q <= wd_interval_i;
         if (go_fb) fb_q <= fb_code_i;
         upd_fb_o    <= go_fb;
         upd_strap_o <= go_strap;
         clr_en_o    <= go_fb || go_strap || ack;
         clr_mstep_o <= go_fb || go_strap;
      end
   end

   assign wd_rst_no = !fg_in_pulse(state_q);

   fg_prescaler #(.TICK_CYC(TICK_CYC), .PULSE_CYC(PULSE_CYC)) i_pre (
      .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(cnt_clr),
      .tick_o(tick), .pulse_end_o(pulse_end)
   );

   fg_sec_counter #(.IV_W(IV_W)) i_sec (
      .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(cnt_clr),
      .tick_i(tick), .limit_i(iv_q), .expire_o(expire)
   );

   fg_code_mux #(.CODE_W(CODE_W)) i_mux (
      .state_i(state_q), .sw_src_i(sw_src_i), .sw_code_i(sw_code_i),
      .strap_code_i(strap_code_i), .fb_hold_i(fb_q), .code_o(freq_code_o)
   );
endmodule

// File: rtl/freq_guard_chk.sv
module freq_guard_chk #(
   parameter int PULSE_CYC = 8,
   parameter int CODE_W    = 5
) (
   input logic              clk_i,
   input logic              rst_ni,
   input logic              wd_rst_no,
   input logic              upd_fb_o,
   input logic              upd_strap_o,
   input logic              clr_en_o,
   input logic              clr_mstep_o,
   input logic [CODE_W-1:0] freq_code_o,
   input logic [CODE_W-1:0] fb_code_i,
   input logic [CODE_W-1:0] strap_code_i
);
   int unsigned low_cnt;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)         low_cnt <= 0;
      else if (!wd_rst_no) low_cnt <= low_cnt + 1;
      else                 low_cnt <= 0;
   end

   a_r4_pulse_len: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(wd_rst_no) |-> (low_cnt == PULSE_CYC));

   a_r5_fall_strobes: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(wd_rst_no) |-> (clr_en_o && clr_mstep_o));

   a_r5_fb_code: assert property (@(posedge clk_i) disable iff (!rst_ni)
      upd_fb_o |-> (!wd_rst_no && freq_code_o == $past(fb_code_i)));

   a_r6_strap_code: assert property (@(posedge clk_i) disable iff (!rst_ni)
      upd_strap_o |-> (!wd_rst_no && freq_code_o == strap_code_i));

   a_r9_one_update: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0({upd_fb_o, upd_strap_o}));
endmodule

bind freq_guard_wdt freq_guard_chk #(.PULSE_CYC(PULSE_CYC), .CODE_W(CODE_W)) i_chk (
   .clk_i(clk_i), .rst_ni(rst_ni), .wd_rst_no(wd_rst_no),
   .upd_fb_o(upd_fb_o), .upd_strap_o(upd_strap_o), .clr_en_o(clr_en_o),
   .clr_mstep_o(clr_mstep_o), .freq_code_o(freq_code_o),
   .fb_code_i(fb_code_i), .strap_code_i(strap_code_i)
);

// File: tb/test_freq_guard_wdt.sv
module test_freq_guard_wdt;
   localparam int TICK  = 20;
   localparam int PULSE = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       en = 1'b0;
   logic [5:0] iv = '0;
   logic [4:0] fb = '0, sw = '0, strap = 5'd7;
   logic       src = 1'b0;
   logic [4:0] code;
   logic       wrst_n, u_fb, u_strap, c_en, c_ms;
   logic [7:0] mstep = 8'h00;

   int checks = 0, fails = 0;
   int n_fb = 0, n_strap = 0, n_clr = 0, n_ms = 0;

   always #2.5 clk = ~clk;

   freq_guard_wdt #(.TICK_CYC(TICK), .PULSE_CYC(PULSE)) i_freq_guard_wdt (
      .clk_i(clk), .rst_ni(rst_n), .wd_en_i(en), .wd_interval_i(iv),
      .fb_code_i(fb), .sw_code_i(sw), .sw_src_i(src), .strap_code_i(strap),
      .freq_code_o(code), .wd_rst_no(wrst_n), .upd_fb_o(u_fb),
      .upd_strap_o(u_strap), .clr_en_o(c_en), .clr_mstep_o(c_ms)
   );

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // one clock; register-file model reacts to strobes at the falling edge
   task automatic step();
      @(posedge clk);
      @(negedge clk);
      if (u_fb)    begin sw = fb; src = 1'b1; n_fb++; end
      if (u_strap) begin src = 1'b0; n_strap++; end
      if (c_en)    begin en = 1'b0; n_clr++; end
      if (c_ms)    begin mstep = 8'h00; n_ms++; end
   endtask

   task automatic wait_lvl(input logic lvl, input int lim, output int n);
      n = 0;
      while (wrst_n !== lvl && n < lim) begin step(); n++; end
   endtask

   task automatic clear_counts();
      n_fb = 0; n_strap = 0; n_clr = 0; n_ms = 0;
   endtask

   initial begin
      #(200000 * 5);
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

   initial begin
      int n, m;
      #12 rst_n = 1'b1;
      @(negedge clk);
      // reset state
      chk("R1 reset rst_n", wrst_n, 1);
      chk("R1 reset code", code, 7);
      chk("R9 reset strobes", {u_fb, u_strap, c_en, c_ms}, 0);

      // R1: exhaustive code sweep, both sources
      for (int s = 0; s < 2; s++) begin
         for (int c = 0; c < 32; c++) begin
            src = s[0]; sw = c[4:0]; strap = 5'(31 - c);
            step();
            chk("R1 code select", code, s ? c : 31 - c);
         end
      end

      // R2/R4/R5/R8: interval sweep with acknowledge in fall-back watch
      for (int k = 0; k < 9; k++) begin
         int nv;
         nv = (k == 8) ? 63 : k;
         m = (nv == 0) ? 1 : nv;
         clear_counts();
         src = 1'b1; sw = 5'd3; strap = 5'd9; fb = 5'(10 + k);
         mstep = 8'h8B; iv = 6'(nv); en = 1'b1;
         wait_lvl(1'b0, 70 * TICK, n);
         chk("R2 expiry edge", n, m * TICK + 1);
         chk("R5 fb code in pulse", code, 10 + k);
         chk("R5 strobes", n_fb * 100 + n_clr * 10 + n_ms, 111);
         chk("R5 micro-step cleared", mstep, 0);
         wait_lvl(1'b1, 4 * PULSE, n);
         chk("R4 pulse length", n, PULSE);
         chk("R5 fb code in watch", code, 10 + k);
         en = 1'b1;                       // acknowledge
         step();
         chk("R8 ack clears enable", n_clr * 10 + int'(en), 20);
         for (int t = 0; t < (m + 1) * TICK; t++) begin
            step();
            if (wrst_n !== 1'b1 || code !== 5'(10 + k)) break;
         end
         chk("R8 no further reset", wrst_n, 1);
         chk("R8 fb kept via register", code, 10 + k);
         chk("R9 no strap update", n_strap, 0);
      end

      // R6: double expiry, no acknowledge
      clear_counts();
      src = 1'b1; sw = 5'd4; strap = 5'd21; fb = 5'd17; iv = 6'd2;
      mstep = 8'h05; en = 1'b1;
      wait_lvl(1'b0, 10 * TICK, n);
      chk("R6 first expiry", n, 2 * TICK + 1);
      wait_lvl(1'b1, 4 * PULSE, n);
      chk("R6 fb during watch", code, 17);
      mstep = 8'h7F;
      wait_lvl(1'b0, 10 * TICK, n);
      chk("R6 second expiry", n, 2 * TICK);
      chk("R6 strap code in pulse", code, 21);
      chk("R6 micro-step cleared", mstep, 0);
      chk("R6 strobe counts", n_fb * 1000 + n_strap * 100 + n_clr * 10 + n_ms, 1122);
      wait_lvl(1'b1, 4 * PULSE, n);
      chk("R4 second pulse length", n, PULSE);
      for (int t = 0; t < 4 * TICK; t++) step();
      chk("R6 strap code after", code, 21);
      chk("R6 idle no reset", wrst_n, 1);

      // R7: disable before expiry
      clear_counts();
      src = 1'b1; sw = 5'd12; fb = 5'd30; iv = 6'd3; mstep = 8'h42; en = 1'b1;
      for (int t = 0; t < 2 * TICK; t++) step();
      en = 1'b0;
      n = 0;
      for (int t = 0; t < 6 * TICK; t++) begin
         step();
         if (wrst_n !== 1'b1) n++;
      end
      chk("R7 no pulse", n, 0);
      chk("R7 no strobes", n_fb + n_strap + n_clr + n_ms, 0);
      chk("R7 code kept", code, 12);
      chk("R7 micro-step kept", mstep, 8'h42);

      // R3: interval rewrite while counting is ignored
      clear_counts();
      iv = 6'd2; en = 1'b1;
      step();
      iv = 6'd63;
      wait_lvl(1'b0, 70 * TICK, n);
      chk("R3 captured interval", n + 1, 2 * TICK + 1);
      wait_lvl(1'b1, 4 * PULSE, n);
      en = 1'b1;
      step();
      for (int t = 0; t < 2; t++) step();

      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end
endmodule